// File: doc/BRIEF.md
# SD Four-Bit Data Path

This block carries SD data blocks across the four data lines DAT0 to DAT3. The SD clock is supplied from outside the block and is sampled in the system clock domain. A pulse on `start` latches the direction and a word count. `mode_tx` set to 1 selects transmit and 0 selects receive. The transfer then runs until that many 32-bit words have crossed the lines, and a single-cycle `done` pulse marks the end.

Receive mode waits until DAT0 reads low. The first SD clock rising edge after that belongs to the start bit and is discarded. Every later rising edge captures one nibble, and eight nibbles make one word on `rx_data`, which is flagged for one cycle by `rx_valid`. Any check words the card sends after the payload are simply more words, so the word count must include them.

Transmit mode takes words from `tx_data`/`tx_valid`/`tx_ready` and puts one nibble on the lines after each SD clock falling edge. The upstream source supplies all of the framing: a leading 0xF0 byte for the start token, 0xFF padding bytes and the trailing check bits. Upstream must also present the next word before the following falling edge.

Top module: `sd_nibble_datapath`

## Requirements
- R1: In the cycle after `rst` is released, `sd_dat_oe`, `rx_valid`, `done`, `busy` and `tx_ready` are all 0.
- R2: In receive mode, SD clock edges that arrive while DAT0 is high produce no `rx_valid`.
- R3: The first rising edge after DAT0 reads low is the start bit and is not captured. Capture begins on the next rising edge.
- R4: In receive mode, DAT3 is the most significant bit of each nibble. The first nibble received fills `rx_data[31:28]` and the eighth fills `rx_data[3:0]`.
- R5: Receive stops after exactly `word_count` words. Later SD clock edges produce no further `rx_valid`.
- R6: In transmit mode, `sd_dat_oe` rises only after an SD clock falling edge, while the SD clock is low.
- R7: In transmit mode, bits 31:28 of each word go on the lines first and bits 3:0 go last. DAT3 carries the most significant bit of each nibble.
- R8: `sd_dat_oe` is 1 only in transmit mode. It covers exactly `8*word_count` SD clock rising edges and falls at the falling edge that follows the last nibble.
- R9: Exactly `word_count` words are accepted on the transmit stream, and `tx_ready` drops after each accepted word.
- R10: A `word_count` of 0 gives a `done` pulse with no line activity and no `rx_valid`.
- R11: `done` is a single-cycle pulse, raised once per transfer.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_tx | input | 1 | Direction sampled at `start`: 1 transmit, 0 receive |
| start | input | 1 | Begins a transfer when the block is idle |
| word_count | input | CNT_W | Number of 32-bit words to move |
| sd_clk_in | input | 1 | SD clock, asynchronous to `clk` |
| sd_dat_in | input | 4 | Data lines as received, bit 3 is DAT3 |
| sd_dat_out | output | 4 | Data lines to drive, bit 3 is DAT3 |
| sd_dat_oe | output | 1 | Output enable for the data lines |
| rx_data | output | WORD_W | Received word |
| rx_valid | output | 1 | One-cycle strobe for `rx_data` |
| tx_data | input | WORD_W | Word to transmit |
| tx_valid | input | 1 | `tx_data` is valid |
| tx_ready | output | 1 | Block accepts `tx_data` this cycle |
| busy | output | 1 | A transfer is in progress |
| done | output | 1 | One-cycle pulse at the end of a transfer |

## Verification
A start bit that was wrongly captured, or a nibble counter that is off by one, rotates every received word by one nibble. This shows in the first `rx_valid`, at most nine SD clock periods after the start bit. A word counter that is wrong changes how many words are delivered or accepted, or moves the point where `sd_dat_oe` drops, and this is visible at the end of the transfer. A transmit shifter that loses its phase produces wrong nibbles at the very first rising edge, where they can be compared against the word just handed over.

// File: rtl/sd_dp_pkg.sv
package sd_dp_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RX_WAIT_LOW,
    ST_RX_WAIT_EDGE,
    ST_RX_RUN,
    ST_TX_LOAD,
    ST_TX_RUN,
    ST_TX_TAIL
  } dp_state_t;
endpackage

// File: rtl/sd_dp_sync.sv
// Multi-stage synchroniser for a bus sampled as one unit.
module sd_dp_sync #(
  parameter int W = 5,
  parameter int STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] async_in,
  output logic [W-1:0] sync_out
);
  logic [W-1:0] stage [STAGES];

  genvar i;
  generate
    for (i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) stage[0] <= RST_VAL;
          else     stage[0] <= async_in;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) stage[i] <= RST_VAL;
          else     stage[i] <= stage[i-1];
        end
      end
    end
  endgenerate

  assign sync_out = stage[STAGES-1];
endmodule

// File: rtl/sd_dp_edge.sv
// Rise and fall detection on a synchronised level.
module sd_dp_edge (
  input  logic clk,
  input  logic rst,
  input  logic level,
  output logic rise,
  output logic fall
);
  logic level_q;

  always_ff @(posedge clk) begin
    if (rst) level_q <= 1'b0;
    else     level_q <= level;
  end

  assign rise = level & ~level_q;
  assign fall = ~level & level_q;
endmodule

// File: rtl/sd_dp_shifter.sv
// Shared word shift register: packs nibbles on receive, unpacks on transmit.
module sd_dp_shifter #(
  parameter int WORD_W = 32,
  parameter int NIB_W  = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [WORD_W-1:0] load_word,
  input  logic              shift,
  input  logic [NIB_W-1:0]  shift_in,
  output logic [WORD_W-1:0] word,
  output logic [NIB_W-1:0]  top_nib
);
  always_ff @(posedge clk) begin
    if (rst)        word <= '0;
    else if (load)  word <= load_word;
    else if (shift) word <= {word[WORD_W-NIB_W-1:0], shift_in};
  end

  assign top_nib = word[WORD_W-1 -: NIB_W];
endmodule

// File: rtl/sd_dp_counter.sv
// Nibble-within-word and word counters shared by both directions.
module sd_dp_counter #(
  parameter int NPW   = 8,
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clear,
  input  logic             step,
  output logic             nib_last,
  output logic [CNT_W-1:0] words
);
  localparam int NW = (NPW > 1) ? $clog2(NPW) : 1;

  logic [NW-1:0] nib;

  assign nib_last = (nib == NW'(NPW - 1));

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      nib   <= '0;
      words <= '0;
    end else if (step) begin
      if (nib_last) begin
        nib   <= '0;
        words <= words + CNT_W'(1);
      end else begin
        nib <= nib + NW'(1);
      end
    end
  end
endmodule

// File: rtl/sd_nibble_datapath.sv
module sd_nibble_datapath
  import sd_dp_pkg::*;
#(
  parameter int WORD_W      = 32,
  parameter int NIB_W       = 4,
  parameter int CNT_W       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              mode_tx,
  input  logic              start,
  input  logic [CNT_W-1:0]  word_count,
  input  logic              sd_clk_in,
  input  logic [NIB_W-1:0]  sd_dat_in,
  output logic [NIB_W-1:0]  sd_dat_out,
  output logic              sd_dat_oe,
  output logic [WORD_W-1:0] rx_data,
  output logic              rx_valid,
  input  logic [WORD_W-1:0] tx_data,
  input  logic              tx_valid,
  output logic              tx_ready,
  output logic              busy,
  output logic              done
);
  localparam int NPW = WORD_W / NIB_W;
  localparam int SW  = NIB_W + 1;

  dp_state_t        state;
  logic [CNT_W-1:0] target;
  logic [SW-1:0]    sync_bus;
  logic             clk_s;
  logic [NIB_W-1:0] dat_s;
  logic             rise, fall;
  logic             nib_last;
  logic [CNT_W-1:0] words;
  logic             last_word;
  logic             step;
  logic             ld_word;
  logic [WORD_W-1:0] sh_word;
  logic [NIB_W-1:0] sh_top;
  logic [NIB_W-1:0] sh_in;

  // Clock and data lines sampled together so a nibble aligns with its edge.
  sd_dp_sync #(
    .W(SW), .STAGES(SYNC_STAGES), .RST_VAL({1'b0, {NIB_W{1'b1}}})
  ) u_sync (
    .clk(clk), .rst(rst),
    .async_in({sd_clk_in, sd_dat_in}),
    .sync_out(sync_bus)
  );

  assign clk_s = sync_bus[SW-1];
  assign dat_s = sync_bus[NIB_W-1:0];

  sd_dp_edge u_edge (
    .clk(clk), .rst(rst), .level(clk_s), .rise(rise), .fall(fall)
  );

  assign step    = ((state == ST_RX_RUN) && rise) || ((state == ST_TX_RUN) && fall);
  assign ld_word = (state == ST_TX_LOAD) && tx_valid;
  assign sh_in   = (state == ST_RX_RUN) ? dat_s : {NIB_W{1'b1}};

  sd_dp_counter #(.NPW(NPW), .CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst(rst),
    .clear((state == ST_IDLE) && start),
    .step(step),
    .nib_last(nib_last),
    .words(words)
  );

  sd_dp_shifter #(.WORD_W(WORD_W), .NIB_W(NIB_W)) u_shift (
    .clk(clk), .rst(rst),
    .load(ld_word), .load_word(tx_data),
    .shift(step), .shift_in(sh_in),
    .word(sh_word), .top_nib(sh_top)
  );

  assign last_word = ((words + CNT_W'(1)) == target);
  assign tx_ready  = (state == ST_TX_LOAD);
  assign busy      = (state != ST_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= ST_IDLE;
      target     <= '0;
      rx_data    <= '0;
      rx_valid   <= 1'b0;
      done       <= 1'b0;
      sd_dat_oe  <= 1'b0;
      sd_dat_out <= '1;
    end else begin
      rx_valid <= 1'b0;
      done     <= 1'b0;
      unique case (state)
        ST_IDLE: begin
          if (start) begin
            target <= word_count;
            if (word_count == '0) done <= 1'b1;
            else if (mode_tx)     state <= ST_TX_LOAD;
            else                  state <= ST_RX_WAIT_LOW;
          end
        end
        ST_RX_WAIT_LOW: begin
          if (!dat_s[0]) state <= ST_RX_WAIT_EDGE;
        end
        ST_RX_WAIT_EDGE: begin
          // This rising edge carries the start bit; it is skipped.
          if (rise) state <= ST_RX_RUN;
        end
        ST_RX_RUN: begin
          if (rise && nib_last) begin
            rx_data  <= {sh_word[WORD_W-NIB_W-1:0], dat_s};
            rx_valid <= 1'b1;
            if (last_word) begin
              done  <= 1'b1;
              state <= ST_IDLE;
            end
          end
        end
        ST_TX_LOAD: begin
          if (tx_valid) state <= ST_TX_RUN;
        end
        ST_TX_RUN: begin
          if (fall) begin
            sd_dat_out <= sh_top;
            sd_dat_oe  <= 1'b1;
            if (nib_last) state <= last_word ? ST_TX_TAIL : ST_TX_LOAD;
          end
        end
        ST_TX_TAIL: begin
          if (fall) begin
            sd_dat_oe  <= 1'b0;
            sd_dat_out <= '1;
            done       <= 1'b1;
            state      <= ST_IDLE;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/sd_dp_checker.sv
module sd_dp_checker (
  input logic clk,
  input logic rst,
  input logic sd_dat_oe,
  input logic rx_valid,
  input logic tx_ready,
  input logic tx_valid,
  input logic busy,
  input logic done
);
  // R1
  reset_state_chk: assert property (@(posedge clk)
    rst |=> (!sd_dat_oe && !rx_valid && !done && !busy && !tx_ready));

  // R8
  oe_rx_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(sd_dat_oe && rx_valid));

  // R8
  oe_release_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(sd_dat_oe) |-> done);

  // R5
  rx_strobe_chk: assert property (@(posedge clk) disable iff (rst)
    rx_valid |=> !rx_valid);

  // R9
  ready_drop_chk: assert property (@(posedge clk) disable iff (rst)
    (tx_ready && tx_valid) |=> !tx_ready);

  // R11
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
endmodule

bind sd_nibble_datapath sd_dp_checker u_chk (
  .clk(clk), .rst(rst), .sd_dat_oe(sd_dat_oe), .rx_valid(rx_valid),
  .tx_ready(tx_ready), .tx_valid(tx_valid), .busy(busy), .done(done)
);

// File: tb/sd_nibble_datapath_tb.sv
`timescale 1ns/1ps
module sd_nibble_datapath_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        sd_clk = 1'b0;
  logic        mode_tx = 1'b0;
  logic        start = 1'b0;
  logic [7:0]  word_count = '0;
  logic [3:0]  sd_dat_in = 4'hF;
  logic [3:0]  sd_dat_out;
  logic        sd_dat_oe;
  logic [31:0] rx_data;
  logic        rx_valid;
  logic [31:0] tx_data;
  logic        tx_valid = 1'b0;
  logic        tx_ready;
  logic        busy;
  logic        done;

  int n_cmp = 0;
  int n_bad = 0;

  sd_nibble_datapath u_dut (
    .clk(clk), .rst(rst), .mode_tx(mode_tx), .start(start),
    .word_count(word_count), .sd_clk_in(sd_clk), .sd_dat_in(sd_dat_in),
    .sd_dat_out(sd_dat_out), .sd_dat_oe(sd_dat_oe), .rx_data(rx_data),
    .rx_valid(rx_valid), .tx_data(tx_data), .tx_valid(tx_valid),
    .tx_ready(tx_ready), .busy(busy), .done(done)
  );

  always #2.5 clk = ~clk;
  initial forever #40 sd_clk = ~sd_clk;

  function automatic logic [31:0] pat(int k, int w);
    return (32'h9E3779B9 * (k + 1)) ^ (32'h0F1E2D3C + w * 32'h01030507);
  endfunction

  task automatic check(bit ok, string req, string what, logic [31:0] act, logic [31:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // Monitors
  logic [31:0] rx_buf [16];
  logic [3:0]  tx_nib [64];
  int rx_n = 0, tx_n = 0, done_n = 0, oe_rx_n = 0, oe_early = 0, oe_seen = 0;
  logic oe_q = 1'b0;
  int tx_k = 0;
  int tx_acc = 0;
  int tx_base = 0;

  assign tx_data = pat(tx_k, tx_acc - tx_base);

  always @(posedge clk) if (tx_ready && tx_valid) tx_acc <= tx_acc + 1;

  always @(negedge clk) begin
    if (!rst) begin
      if (rx_valid) begin
        if (rx_n < 16) rx_buf[rx_n] = rx_data;
        rx_n++;
      end
      if (done) done_n++;
      if (sd_dat_oe) oe_seen++;
      if (sd_dat_oe && !mode_tx) oe_rx_n++;
      if (sd_dat_oe && !oe_q && sd_clk !== 1'b0) oe_early++;
      oe_q = sd_dat_oe;
    end
  end

  always @(posedge sd_clk) begin
    if (!rst && sd_dat_oe) begin
      if (tx_n < 64) tx_nib[tx_n] = sd_dat_out;
      tx_n++;
    end
  end

  task automatic clear_mon();
    rx_n = 0; tx_n = 0; done_n = 0; oe_rx_n = 0; oe_early = 0; oe_seen = 0;
  endtask

  task automatic kick(bit tx, int n);
    @(negedge clk);
    mode_tx = tx; word_count = n[7:0]; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic run_rx(int k, int n);
    logic [31:0] w;
    clear_mon();
    sd_dat_in = 4'hF;
    kick(1'b0, n);
    repeat (3) @(negedge sd_clk);
    check(rx_n == 0, "R2", "words before start bit", rx_n, 0);
    @(negedge sd_clk) sd_dat_in = 4'h0;
    for (int j = 0; j < n; j++) begin
      w = pat(k, j);
      for (int i = 0; i < 8; i++) begin
        @(negedge sd_clk) sd_dat_in = 4'((w >> (28 - 4 * i)) & 32'hF);
      end
    end
    for (int i = 0; i < 8; i++) @(negedge sd_clk) sd_dat_in = 4'h5;
    @(negedge sd_clk) sd_dat_in = 4'hF;
    repeat (4) @(negedge clk);
    check(rx_n == n, "R5", "received word count", rx_n, n);
    for (int j = 0; j < n && j < 16; j++)
      check(rx_buf[j] == pat(k, j), "R3 R4", "received word", rx_buf[j], pat(k, j));
    check(done_n == 1, "R11", "done pulses (rx)", done_n, 1);
    check(oe_rx_n == 0, "R8", "oe during receive", oe_rx_n, 0);
    check(busy == 1'b0, "R5", "busy after receive", busy, 0);
  endtask

  task automatic run_tx(int k, int n);
    int guard;
    logic [31:0] w;
    clear_mon();
    @(negedge clk);
    tx_k = k; tx_base = tx_acc; tx_valid = 1'b1;
    kick(1'b1, n);
    guard = 0;
    while (done_n == 0 && guard < 400 * (n + 2)) begin
      @(negedge clk);
      guard++;
    end
    tx_valid = 1'b0;
    check(done_n == 1, "R11", "done pulses (tx)", done_n, 1);
    check(sd_dat_oe == 1'b0, "R8", "oe after done", sd_dat_oe, 0);
    check(tx_n == 8 * n, "R8", "driven nibble count", tx_n, 8 * n);
    check(tx_acc - tx_base == n, "R9", "accepted words", tx_acc - tx_base, n);
    check(oe_early == 0, "R6", "oe rose while sd clock high", oe_early, 0);
    for (int j = 0; j < n; j++) begin
      w = pat(k, j);
      for (int i = 0; i < 8; i++) begin
        if (8 * j + i < 64)
          check(tx_nib[8 * j + i] == 4'((w >> (28 - 4 * i)) & 32'hF), "R7",
                "driven nibble", tx_nib[8 * j + i], (w >> (28 - 4 * i)) & 32'hF);
      end
    end
    repeat (4) @(negedge sd_clk);
    check(tx_n == 8 * n, "R8", "no nibbles after release", tx_n, 8 * n);
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  initial begin
    #1_000_000;
    n_cmp++; n_bad++;
    $display("FAIL R5 watchdog: actual hung expected finished");
    summary();
    $finish;
  end

  initial begin
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check(!sd_dat_oe && !rx_valid && !done && !busy && !tx_ready, "R1", "reset outputs",
          {27'd0, sd_dat_oe, rx_valid, done, busy, tx_ready}, 0);

    for (int k = 0; k < 2; k++)
      for (int n = 1; n <= 3; n++) run_rx(k, n);

    for (int k = 2; k < 4; k++)
      for (int n = 1; n <= 3; n++) run_tx(k, n);

    // R10: empty transfer in both directions
    for (int d = 0; d < 2; d++) begin
      clear_mon();
      kick(d[0], 0);
      repeat (4) @(negedge clk);
      check(done_n == 1, "R10", "done for zero count", done_n, 1);
      check(oe_seen == 0 && rx_n == 0, "R10", "activity for zero count", oe_seen + rx_n, 0);
      check(busy == 1'b0, "R10", "busy for zero count", busy, 0);
    end

    summary();
    $finish;
  end
endmodule